// File: doc/BRIEF.md
# Multicore Reset and Boot Controller

This block is a register file that software uses to start, stop and reset the cores of a four-core cluster, and to fire soft resets at two peripherals. It exposes sixteen 32-bit word registers on a simple bus with a single write strobe and a combinational read path. The word index is the byte address shifted right by two. The block spans a 4 KiB address window, and any index above 15 reads as zero and ignores writes.

Actions come only from writes to the control register at index 0. The block XORs the written word with the stored word to get a change mask, and only the changed bits produce requests. Changing a core's enable bit starts or stops that core. A start request carries an entry address and a context word, both taken from a general-purpose register pair. Changing a core's reset bit sends a reset request to that core. The reset bit then keeps the written value until the core returns a done pulse, which clears it. The two peripheral soft-reset bits act as triggers: when either one changes, the block emits a pulse and stores that bit as 0.

Top module: `core_boot_ctl`

## Requirements
- R1: After reset, index 0 reads 0x00000521, index 2 reads 0x00000001, index 4 reads 0x0000001F, every other index reads 0, and every request output is 0.
- R2: A read returns the register at index busAddr[11:2]. Indices 16 to 1023 read as 0. Writes to those indices change no register and raise no request.
- R3: A write to any index from 1 to 15 stores the written word unchanged, and it reads back unchanged. The registers at indices 8 to 13 hold the boot address pairs: 8/9 for core 1, 10/11 for core 2 and 12/13 for core 3.
- R4: In the cycle after the write clock edge, a control write that takes the enable bit of core c (bit 21+c, for c = 1, 2, 3) from 0 to 1 pulses coreStart[c] for one cycle. In that same cycle, coreEntry lane c holds register 6+2c and coreContext lane c holds register 7+2c, both as they were before the write.
- R5: A control write that takes the enable bit of core c from 1 to 0 pulses coreStop[c] for one cycle, in the cycle after the write clock edge.
- R6: When a write changes the enable bit of core c, it raises no coreReset[c] for that write, even if the reset bit of core c also changes.
- R7: A change of the reset bit of core c (bit 13+c, for c = 0 to 3) pulses coreReset[c] for one cycle, except in the case R6 covers.
- R8: The control register stores the written word, apart from the cases R9 covers. A reset bit keeps that value until coreDone[c] is high at a clock edge. That edge clears the bit, and the clear wins over a bus write to the same bit on the same edge.
- R9: When a control write changes bit 3 or bit 12, periphReset[0] or periphReset[1] respectively pulses for one cycle, and that bit is stored as 0. Neither bit ever reads as 1.
- R10: A control write that changes no bit raises no request of any kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe for the word at busAddr |
| busAddr | input | 12 | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| coreDone | input | 4 | Per-core completion pulse; clears that core's reset bit |
| coreStart | output | 4 | Per-core start request pulse (lane 0 unused) |
| coreStop | output | 4 | Per-core power-off request pulse (lane 0 unused) |
| coreReset | output | 4 | Per-core reset request pulse |
| coreEntry | output | 128 | Entry address, 32 bits per core lane |
| coreContext | output | 128 | Context word, 32 bits per core lane |
| periphReset | output | 2 | Peripheral soft-reset pulses (bit 3, bit 12) |

## Verification
The assertions assume that every bus write uses a word-aligned address. The bench keeps its addresses aligned, so the low two address bits are always zero. The assertions place no rule on when coreDone arrives: done may come while no reset is pending, or in the same cycle as a bus write. The bench drives both cases, including a done pulse in the same cycle as a control write that sets that core's reset bit. The sweep writes the control register 128 times with multi-bit changes in the enable, reset and trigger fields. After every eighth write it returns done pulses for all four cores.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_REGS  = 16;
  localparam int NUM_CORES = 4;
  localparam int ADDR_W    = 12;
  localparam int IDX_W     = ADDR_W - 2;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int NUM_PERIPH = 2;

  // register indices
  localparam int IDX_CTL    = 0;
  localparam int IDX_STAT   = 2;
  localparam int IDX_IMASK  = 4;
  localparam int GPR_BASE   = 6;   // core c uses GPR_BASE+2c / +2c+1

  // control register bit positions
  localparam int RST_BASE   = 13;  // core c reset at RST_BASE+c
  localparam int EN_BASE    = 22;  // core c (c>=1) enable at EN_BASE+c-1
  localparam int PERIPH_LO  = 3;
  localparam int PERIPH_HI  = 12;

  localparam logic [DATA_W-1:0] CTL_INIT   = 32'h0000_0521;
  localparam logic [DATA_W-1:0] STAT_INIT  = 32'h0000_0001;
  localparam logic [DATA_W-1:0] IMASK_INIT = 32'h0000_001F;

  typedef struct packed {
    logic [NUM_REGS-1:0]   regWe;
    logic [DATA_W-1:0]     wdata;
    logic [DATA_W-1:0]     ctlData;
    logic [NUM_CORES-1:0]  startReq;
    logic [NUM_CORES-1:0]  stopReq;
    logic [NUM_CORES-1:0]  rstReq;
    logic [NUM_PERIPH-1:0] periphReq;
  } strobe_t;

  function automatic logic [DATA_W-1:0] initValue(int idx);
    case (idx)
      IDX_CTL:   return CTL_INIT;
      IDX_STAT:  return STAT_INIT;
      IDX_IMASK: return IMASK_INIT;
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/cbc_ctl.sv
module cbc_ctl
  import cbc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] ctlQ,
  output strobe_t           strobe
);
  logic [IDX_W-1:0]     wrIdx;
  logic                 wrHit;
  logic [DATA_W-1:0]    chgMask;
  logic [NUM_CORES-1:0] launchHit;

  assign wrIdx   = busAddr[ADDR_W-1:2];
  assign wrHit   = busWrite && (wrIdx < IDX_W'(NUM_REGS));
  assign chgMask = ctlQ ^ busWdata;

  always_comb begin
    strobe         = '0;
    strobe.wdata   = busWdata;
    strobe.ctlData = busWdata;
    launchHit      = '0;
    if (wrHit) begin
      strobe.regWe[wrIdx[REG_IDX_W-1:0]] = 1'b1;
    end
    if (wrHit && wrIdx == IDX_W'(IDX_CTL)) begin
      for (int c = 1; c < NUM_CORES; c++) begin
        if (chgMask[EN_BASE+c-1]) begin
          launchHit[c] = 1'b1;
          if (busWdata[EN_BASE+c-1]) strobe.startReq[c] = 1'b1;
          else                       strobe.stopReq[c]  = 1'b1;
        end
      end
      for (int c = 0; c < NUM_CORES; c++) begin
        if (chgMask[RST_BASE+c] && !launchHit[c]) strobe.rstReq[c] = 1'b1;
      end
      if (chgMask[PERIPH_LO]) begin
        strobe.ctlData[PERIPH_LO] = 1'b0;
        strobe.periphReq[0]       = 1'b1;
      end
      if (chgMask[PERIPH_HI]) begin
        strobe.ctlData[PERIPH_HI] = 1'b0;
        strobe.periphReq[1]       = 1'b1;
      end
    end
  end

  // R2: input rule - bus writes are word aligned
  a_r2_aligned_write: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> busAddr[1:0] == 2'b00);
endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strobe,
  input  logic [IDX_W-1:0]              rdIdx,
  input  logic [NUM_CORES-1:0]          coreDone,
  output logic [DATA_W-1:0]             busRdata,
  output logic [DATA_W-1:0]             ctlQ,
  output logic [NUM_CORES-1:0]          coreStart,
  output logic [NUM_CORES-1:0]          coreStop,
  output logic [NUM_CORES-1:0]          coreReset,
  output logic [NUM_CORES*DATA_W-1:0]   coreEntry,
  output logic [NUM_CORES*DATA_W-1:0]   coreContext,
  output logic [NUM_PERIPH-1:0]         periphReset
);
  logic [DATA_W-1:0] regQ   [NUM_REGS];
  logic [DATA_W-1:0] entryQ [NUM_CORES];
  logic [DATA_W-1:0] ctxQ   [NUM_CORES];
  logic [DATA_W-1:0] doneMask;

  always_comb begin
    doneMask = '0;
    for (int c = 0; c < NUM_CORES; c++) doneMask[RST_BASE+c] = coreDone[c];
  end

  // done clears win over a same-edge bus write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= initValue(i);
    end else begin
      regQ[IDX_CTL] <= (strobe.regWe[IDX_CTL] ? strobe.ctlData : regQ[IDX_CTL]) & ~doneMask;
      for (int i = 1; i < NUM_REGS; i++) begin
        if (strobe.regWe[i]) regQ[i] <= strobe.wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreStart   <= '0;
      coreStop    <= '0;
      coreReset   <= '0;
      periphReset <= '0;
      for (int c = 0; c < NUM_CORES; c++) begin
        entryQ[c] <= '0;
        ctxQ[c]   <= '0;
      end
    end else begin
      coreStart   <= strobe.startReq;
      coreStop    <= strobe.stopReq;
      coreReset   <= strobe.rstReq;
      periphReset <= strobe.periphReq;
      for (int c = 1; c < NUM_CORES; c++) begin
        if (strobe.startReq[c]) begin
          entryQ[c] <= regQ[GPR_BASE+2*c];
          ctxQ[c]   <= regQ[GPR_BASE+2*c+1];
        end
      end
    end
  end

  assign ctlQ     = regQ[IDX_CTL];
  assign busRdata = (rdIdx < IDX_W'(NUM_REGS)) ? regQ[rdIdx[REG_IDX_W-1:0]] : '0;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
    assign coreEntry[c*DATA_W +: DATA_W]   = entryQ[c];
    assign coreContext[c*DATA_W +: DATA_W] = ctxQ[c];

    // R8: a done pulse leaves the reset bit clear
    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rstN)
      coreDone[c] |=> !regQ[IDX_CTL][RST_BASE+c]);

    // R6: no reset request for a core that is launched or stopped
    a_r6_launch_masks_reset: assert property (@(posedge clk) disable iff (!rstN)
      (coreStart[c] || coreStop[c]) |-> !coreReset[c]);

    if (c > 0) begin : g_boot
      // R4: boot vector comes from the register pair held before the write
      a_r4_entry_pair: assert property (@(posedge clk) disable iff (!rstN)
        coreStart[c] |-> (entryQ[c] == $past(regQ[GPR_BASE+2*c])) &&
                         (ctxQ[c]   == $past(regQ[GPR_BASE+2*c+1])));
    end
  end

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_plain
    // R3: plain registers keep the written word
    a_r3_plain_store: assert property (@(posedge clk) disable iff (!rstN)
      strobe.regWe[i] |=> regQ[i] == $past(strobe.wdata));
  end

  // R5: start and stop for one core never coincide
  a_r5_start_stop_excl: assert property (@(posedge clk) disable iff (!rstN)
    (coreStart & coreStop) == '0);

  // R9: trigger bits never held as one
  a_r9_trigger_low: assert property (@(posedge clk) disable iff (!rstN)
    !regQ[IDX_CTL][PERIPH_LO] && !regQ[IDX_CTL][PERIPH_HI]);
endmodule

// File: rtl/core_boot_ctl.sv
module core_boot_ctl
  import cbc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busWrite,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [DATA_W-1:0]           busWdata,
  output logic [DATA_W-1:0]           busRdata,
  input  logic [NUM_CORES-1:0]        coreDone,
  output logic [NUM_CORES-1:0]        coreStart,
  output logic [NUM_CORES-1:0]        coreStop,
  output logic [NUM_CORES-1:0]        coreReset,
  output logic [NUM_CORES*DATA_W-1:0] coreEntry,
  output logic [NUM_CORES*DATA_W-1:0] coreContext,
  output logic [NUM_PERIPH-1:0]       periphReset
);
  strobe_t           strobe;
  logic [DATA_W-1:0] ctlQ;

  cbc_ctl ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .ctlQ     (ctlQ),
    .strobe   (strobe)
  );

  cbc_regs regs_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rdIdx       (busAddr[ADDR_W-1:2]),
    .coreDone    (coreDone),
    .busRdata    (busRdata),
    .ctlQ        (ctlQ),
    .coreStart   (coreStart),
    .coreStop    (coreStop),
    .coreReset   (coreReset),
    .coreEntry   (coreEntry),
    .coreContext (coreContext),
    .periphReset (periphReset)
  );
endmodule

// File: tb/core_boot_ctl_tb_top.sv
`timescale 1ns/1ps
module core_boot_ctl_tb_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic         busWrite;
  logic [11:0]  busAddr;
  logic [31:0]  busWdata;
  logic [31:0]  busRdata;
  logic [3:0]   coreDone;
  logic [3:0]   coreStart, coreStop, coreReset;
  logic [127:0] coreEntry, coreContext;
  logic [1:0]   periphReset;

  always #2.5 clk = ~clk;

  core_boot_ctl dut_i (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .coreDone(coreDone),
    .coreStart(coreStart), .coreStop(coreStop), .coreReset(coreReset),
    .coreEntry(coreEntry), .coreContext(coreContext), .periphReset(periphReset)
  );

  int nCmp = 0;
  int nBad = 0;
  logic [31:0] expReg [16];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [11:0] addr, logic [31:0] data);
    @(negedge clk);
    busWrite = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(logic [11:0] addr, output logic [31:0] data);
    busAddr = addr;
    #1 data = busRdata;
  endtask

  task automatic checkQuiet(string req);
    check(req, {20'd0, coreStart, coreStop, coreReset}, 32'd0);
    check(req, {30'd0, periphReset}, 32'd0);
  endtask

  // control write with expected outcome derived from the requirements
  task automatic ctlWrite(logic [31:0] v, logic [3:0] done);
    logic [31:0] chg, stored, rd;
    logic [3:0]  eStart, eStop, eRst, launched;
    logic [1:0]  ePer;
    chg = expReg[0] ^ v;
    eStart = '0; eStop = '0; eRst = '0; launched = '0; ePer = '0;
    stored = v;
    for (int c = 1; c < 4; c++) begin
      if (chg[21+c]) begin
        launched[c] = 1'b1;
        if (v[21+c]) eStart[c] = 1'b1; else eStop[c] = 1'b1;
      end
    end
    for (int c = 0; c < 4; c++) if (chg[13+c] && !launched[c]) eRst[c] = 1'b1;
    if (chg[3])  begin stored[3]  = 1'b0; ePer[0] = 1'b1; end
    if (chg[12]) begin stored[12] = 1'b0; ePer[1] = 1'b1; end
    for (int c = 0; c < 4; c++) if (done[c]) stored[13+c] = 1'b0;
    @(negedge clk);
    busWrite = 1'b1; busAddr = 12'h000; busWdata = v; coreDone = done;
    @(negedge clk);
    busWrite = 1'b0; coreDone = '0;
    expReg[0] = stored;
    check("R4 start", {28'd0, coreStart}, {28'd0, eStart});
    check("R5 stop", {28'd0, coreStop}, {28'd0, eStop});
    check("R6/R7 reset", {28'd0, coreReset}, {28'd0, eRst});
    check("R9 trigger", {30'd0, periphReset}, {30'd0, ePer});
    for (int c = 1; c < 4; c++) begin
      if (eStart[c]) begin
        check("R4 entry", coreEntry[c*32 +: 32], expReg[6+2*c]);
        check("R4 context", coreContext[c*32 +: 32], expReg[7+2*c]);
      end
    end
    busRd(12'h000, rd);
    check("R8 ctl readback", rd, stored);
  endtask

  task automatic doneCycle(logic [3:0] m);
    logic [31:0] rd;
    @(negedge clk);
    coreDone = m;
    @(negedge clk);
    coreDone = '0;
    for (int c = 0; c < 4; c++) if (m[c]) expReg[0][13+c] = 1'b0;
    busRd(12'h000, rd);
    check("R8 done clear", rd, expReg[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; busWrite = 1'b0; busAddr = '0; busWdata = '0; coreDone = '0;
    for (int i = 0; i < 16; i++) expReg[i] = 32'd0;
    expReg[0] = 32'h521; expReg[2] = 32'h1; expReg[4] = 32'h1F;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      busRd(12'(i*4), rd);
      check("R1 reset value", rd, expReg[i]);
    end
    checkQuiet("R1 quiet outputs");

    // R3 plain registers
    for (int i = 1; i < 16; i++) begin
      logic [31:0] w;
      w = 32'h9E37_79B9 * (i + 1);
      busWr(12'(i*4), w);
      expReg[i] = w;
      checkQuiet("R3 no request");
    end
    for (int i = 1; i < 16; i++) begin
      busRd(12'(i*4), rd);
      check("R3 readback", rd, expReg[i]);
    end

    // R2 out-of-window index
    busWr(12'h040, 32'hDEAD_BEEF);
    checkQuiet("R2 ignored write");
    busWr(12'hFFC, 32'h0BAD_F00D);
    checkQuiet("R2 ignored write");
    busRd(12'h040, rd); check("R2 zero read", rd, 32'd0);
    busRd(12'hFFC, rd); check("R2 zero read", rd, 32'd0);
    for (int i = 0; i < 16; i++) begin
      busRd(12'(i*4), rd);
      check("R2 registers untouched", rd, expReg[i]);
    end

    // R10 same-value write
    ctlWrite(expReg[0], 4'h0);
    checkQuiet("R10 no change");

    // R4 launch each core, R5 stop, R6 with reset bit flipped too
    for (int c = 1; c < 4; c++) begin
      logic [31:0] v;
      v = expReg[0]; v[21+c] = 1'b1; v[13+c] = ~v[13+c];
      ctlWrite(v, 4'h0);
      doneCycle(4'(1 << c));
      v = expReg[0]; v[21+c] = 1'b0;
      ctlWrite(v, 4'h0);
    end

    // R7 core 0 reset, then R8 priority of done over write
    ctlWrite(expReg[0] | 32'h0000_2000, 4'h0);
    doneCycle(4'b0001);
    ctlWrite(expReg[0] | 32'h0000_8000, 4'b0100);

    // R9 trigger bits
    ctlWrite(expReg[0] | 32'h0000_1008, 4'h0);

    // sweep over enable/reset/trigger combinations
    for (int k = 0; k < 128; k++) begin
      int p;
      logic [31:0] v;
      p = (k * 37 + 5) % 128;
      v = 32'h521;
      v[24:22] = 3'(p);
      v[16:13] = 4'(p >> 3);
      v[3]     = k[0];
      v[12]    = k[1];
      ctlWrite(v, 4'h0);
      if (k % 8 == 7) doneCycle(4'hF);
    end

    @(negedge clk);
    checkQuiet("R10 idle after sweep");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule